// File: doc/BRIEF.md
# Per-Instruction Pending Packet Table

This block parks read and write memory packets from a compute-unit request port until a downstream coalescing stage takes them. Packets are filed under the sequence number of the instruction that produced them. Each live instruction owns one slot, and a slot keeps its packets in arrival order. The coalescing stage removes packets one at a time by naming an instruction. It also pulses an update strobe. On that strobe every instruction whose packets have all been taken is retired, and the requester gets one flow-control credit back for each retired instruction.

A combinational lookup tells completion-tracking logic whether a given instruction still holds a slot in the table. Memory-sync commands never enter the table and are handed straight to the cache-side issue path. The first accepted insertion starts an issue pass, and no further pass is requested until the coalescer reports that the pass has finished. A watchdog flag marks any slot whose packets have been waiting too long.

Top module: `inst_pkt_table`

## Requirements
- R1: After reset the table holds no instruction: `q_done` is 1 for every sequence number, `tok_count` is 0, `stall_flag` is 0 and `pop_hit` is 0.
- R2: A packet with `in_valid`=1 and `in_cmd` equal to 2'b00 (read) or 2'b01 (write) is stored under `in_seq`. Packets of one instruction leave through `pop_pkt` in the order they arrived, whatever packets of other instructions arrive in between.
- R3: `in_refuse` is 1, in the same cycle, for a read or write packet that cannot be stored. This happens when its instruction already holds DEPTH packets, or when it is new and all NSLOT slots are taken. A refused packet is not stored.
- R4: With `in_cmd`=2'b10 (sync), `sync_valid` is 1 in the same cycle and carries `in_seq` and `in_pkt` on `sync_seq` and `sync_pkt`. The packet is not stored. With `in_cmd`=2'b11 the input is ignored: nothing is stored, refused or kicked.
- R5: `issue_kick` pulses in the cycle of an accepted insertion only when no issue pass is pending. A pass becomes pending with any accepted insertion and stays pending until a cycle with `pass_done`=1.
- R6: With `pop_valid`=1, `pop_hit` is 1 in the same cycle exactly when instruction `pop_seq` holds at least one packet. In that case `pop_pkt` is its oldest packet, and that packet is removed at the clock edge. A pop of an absent or empty instruction changes nothing.
- R7: On an `upd_strobe` cycle, every instruction that holds a slot with no packets is retired, except one receiving a packet in that same cycle. In the following cycle `tok_count` equals the number retired. It is 0 in every other cycle.
- R8: `q_done` is 0 while instruction `q_seq` holds a slot, including an emptied slot not yet retired, and 1 otherwise.
- R9: `stall_flag` is 1 while some slot has held at least one packet for STALL_LIMIT consecutive clock edges without a pop from that slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Incoming request valid |
| in_cmd | input | 2 | 00 read, 01 write, 10 sync, 11 ignored |
| in_seq | input | SEQ_W | Instruction sequence number of the request |
| in_pkt | input | PKT_W | Packet descriptor |
| in_refuse | output | 1 | Read/write request not stored this cycle |
| issue_kick | output | 1 | Start-of-issue-pass pulse |
| pass_done | input | 1 | Coalescer finished the pending issue pass |
| sync_valid | output | 1 | Sync request forwarded to cache-side path |
| sync_seq | output | SEQ_W | Forwarded sync sequence number |
| sync_pkt | output | PKT_W | Forwarded sync descriptor |
| pop_valid | input | 1 | Coalescer requests the oldest packet of `pop_seq` |
| pop_seq | input | SEQ_W | Instruction to pop from |
| pop_hit | output | 1 | A packet is delivered and removed |
| pop_pkt | output | PKT_W | Delivered packet |
| upd_strobe | input | 1 | Resource-update pass: retire emptied instructions |
| tok_count | output | $clog2(NSLOT+1) | Credits returned, one cycle after the strobe |
| q_seq | input | SEQ_W | Sequence number for the issued-all query |
| q_done | output | 1 | Instruction `q_seq` holds no slot |
| stall_flag | output | 1 | A slot has waited STALL_LIMIT edges without a pop |

## Verification
On every cycle, the assertions check several local relations. A refusal never coincides with a kick. A sync request neither stores nor kicks. An unanswered kick is not followed by another. Credits appear only right after an update strobe, and never more than the number of slots. The query reports an instruction as live whenever a pop from it succeeds. Per-instruction ordering, exact credit counts when several instructions retire together, capacity refusal, and the stall timeout all depend on history. Only the bench's behavioural model can establish them, by running directed scenarios and a long mixed stream and comparing every output every cycle.

// File: rtl/ipt_pkg.sv
package ipt_pkg;

  typedef enum logic [1:0] {
    CMD_RD   = 2'b00,
    CMD_WR   = 2'b01,
    CMD_SYNC = 2'b10,
    CMD_NONE = 2'b11
  } ipt_cmd_e;

  // circular pointer advance for a FIFO of arbitrary depth
  function automatic int wrap_inc(int ptr, int depth);
    return (ptr == depth - 1) ? 0 : ptr + 1;
  endfunction

  // wait counter: cleared on a pop or when nothing is held, saturating otherwise
  function automatic int age_step(int age, int limit, bit clear);
    if (clear) return 0;
    return (age < limit) ? age + 1 : age;
  endfunction

  function automatic bit is_data_cmd(logic [1:0] cmd);
    return (cmd == CMD_RD) || (cmd == CMD_WR);
  endfunction

endpackage

// File: rtl/ipt_select.sv
module ipt_select #(
  parameter int N     = 4,
  parameter int IDX_W = 2
) (
  input  logic [N-1:0]     vec,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  // lowest set bit wins
  always_comb begin
    any = |vec;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/ipt_slot.sv
module ipt_slot #(
  parameter int DEPTH = 4,
  parameter int SEQ_W = 8,
  parameter int PKT_W = 16,
  parameter int LIMIT = 48,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int AGE_W = $clog2(LIMIT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_i,
  input  logic [SEQ_W-1:0] tag_i,
  input  logic             push_i,
  input  logic [PKT_W-1:0] pkt_i,
  input  logic             pop_i,
  input  logic             retire_i,
  output logic             valid_o,
  output logic [SEQ_W-1:0] tag_o,
  output logic [CNT_W-1:0] count_o,
  output logic [PKT_W-1:0] head_o,
  output logic             aged_o
);
  logic [PKT_W-1:0] mem [DEPTH];
  logic             valid_q;
  logic [SEQ_W-1:0] tag_q;
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic [AGE_W-1:0] age_q, age_nxt;

  always_comb begin
    cnt_nxt = cnt_q;
    if (push_i && !pop_i) cnt_nxt = cnt_q + CNT_W'(1);
    if (pop_i && !push_i) cnt_nxt = cnt_q - CNT_W'(1);
    age_nxt = AGE_W'(ipt_pkg::age_step(int'(age_q), LIMIT,
                                       pop_i || (cnt_nxt == '0)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      tag_q   <= '0;
      wr_q    <= '0;
      rd_q    <= '0;
      cnt_q   <= '0;
      age_q   <= '0;
    end else begin
      if (alloc_i) begin
        valid_q <= 1'b1;
        tag_q   <= tag_i;
      end else if (retire_i) begin
        valid_q <= 1'b0;
      end
      if (push_i) wr_q <= PTR_W'(ipt_pkg::wrap_inc(int'(wr_q), DEPTH));
      if (pop_i)  rd_q <= PTR_W'(ipt_pkg::wrap_inc(int'(rd_q), DEPTH));
      cnt_q <= cnt_nxt;
      age_q <= age_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (push_i) mem[wr_q] <= pkt_i;
  end

  assign valid_o = valid_q;
  assign tag_o   = tag_q;
  assign count_o = cnt_q;
  assign head_o  = mem[rd_q];
  assign aged_o  = valid_q && (age_q >= AGE_W'(LIMIT));
endmodule

// File: rtl/inst_pkt_table.sv
module inst_pkt_table #(
  parameter int NSLOT       = 4,
  parameter int DEPTH       = 4,
  parameter int SEQ_W       = 8,
  parameter int PKT_W       = 16,
  parameter int STALL_LIMIT = 48,
  localparam int CNT_W  = $clog2(NSLOT + 1),
  localparam int IDX_W  = (NSLOT > 1) ? $clog2(NSLOT) : 1,
  localparam int SCNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [1:0]       in_cmd,
  input  logic [SEQ_W-1:0] in_seq,
  input  logic [PKT_W-1:0] in_pkt,
  output logic             in_refuse,
  output logic             issue_kick,
  input  logic             pass_done,
  output logic             sync_valid,
  output logic [SEQ_W-1:0] sync_seq,
  output logic [PKT_W-1:0] sync_pkt,
  input  logic             pop_valid,
  input  logic [SEQ_W-1:0] pop_seq,
  output logic             pop_hit,
  output logic [PKT_W-1:0] pop_pkt,
  input  logic             upd_strobe,
  output logic [CNT_W-1:0] tok_count,
  input  logic [SEQ_W-1:0] q_seq,
  output logic             q_done,
  output logic             stall_flag
);
  import ipt_pkg::*;

  logic              s_valid [NSLOT];
  logic [SEQ_W-1:0]  s_tag   [NSLOT];
  logic [SCNT_W-1:0] s_cnt   [NSLOT];
  logic [PKT_W-1:0]  s_head  [NSLOT];
  logic [NSLOT-1:0]  s_aged;

  logic [NSLOT-1:0] ins_match, free_vec, pop_match, q_match;
  logic [NSLOT-1:0] push_v, alloc_v, pop_v, retire_v;
  logic             hit_any, free_any, pmatch_any;
  logic [IDX_W-1:0] hit_idx, free_idx, pop_idx;
  logic             data_req, ins_room, ins_accept;
  logic             issue_busy_q;

  // tag comparison per slot
  generate
    for (genvar g = 0; g < NSLOT; g++) begin : g_cmp
      assign ins_match[g] = s_valid[g] && (s_tag[g] == in_seq);
      assign free_vec[g]  = !s_valid[g];
      assign pop_match[g] = s_valid[g] && (s_tag[g] == pop_seq) && (s_cnt[g] != '0);
      assign q_match[g]   = s_valid[g] && (s_tag[g] == q_seq);
    end
  endgenerate

  ipt_select #(.N(NSLOT), .IDX_W(IDX_W)) u_sel_hit (
    .vec(ins_match), .any(hit_any), .idx(hit_idx));
  ipt_select #(.N(NSLOT), .IDX_W(IDX_W)) u_sel_free (
    .vec(free_vec), .any(free_any), .idx(free_idx));
  ipt_select #(.N(NSLOT), .IDX_W(IDX_W)) u_sel_pop (
    .vec(pop_match), .any(pmatch_any), .idx(pop_idx));

  // insertion decision
  assign data_req   = in_valid && is_data_cmd(in_cmd);
  assign ins_room   = hit_any ? (s_cnt[hit_idx] != SCNT_W'(DEPTH)) : free_any;
  assign ins_accept = data_req && ins_room;
  assign in_refuse  = data_req && !ins_room;
  assign issue_kick = ins_accept && !issue_busy_q;

  always_comb begin
    for (int i = 0; i < NSLOT; i++) begin
      push_v[i]   = ins_accept && (hit_any ? (hit_idx == IDX_W'(i))
                                           : (free_idx == IDX_W'(i)));
      alloc_v[i]  = ins_accept && !hit_any && (free_idx == IDX_W'(i));
      pop_v[i]    = pop_valid && pmatch_any && (pop_idx == IDX_W'(i));
      retire_v[i] = upd_strobe && s_valid[i] && (s_cnt[i] == '0) && !push_v[i];
    end
  end

  generate
    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
      ipt_slot #(
        .DEPTH(DEPTH), .SEQ_W(SEQ_W), .PKT_W(PKT_W), .LIMIT(STALL_LIMIT)
      ) u_slot (
        .clk      (clk),
        .rst_n    (rst_n),
        .alloc_i  (alloc_v[g]),
        .tag_i    (in_seq),
        .push_i   (push_v[g]),
        .pkt_i    (in_pkt),
        .pop_i    (pop_v[g]),
        .retire_i (retire_v[g]),
        .valid_o  (s_valid[g]),
        .tag_o    (s_tag[g]),
        .count_o  (s_cnt[g]),
        .head_o   (s_head[g]),
        .aged_o   (s_aged[g])
      );
    end
  endgenerate

  // issue-pass tracking and credit return
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      issue_busy_q <= 1'b0;
      tok_count    <= '0;
    end else begin
      issue_busy_q <= ins_accept || (issue_busy_q && !pass_done);
      tok_count    <= upd_strobe ? CNT_W'($countones(retire_v)) : '0;
    end
  end

  assign pop_hit    = pop_valid && pmatch_any;
  assign pop_pkt    = s_head[pop_idx];
  assign q_done     = !(|q_match);
  assign stall_flag = |s_aged;

  // sync requests bypass storage
  assign sync_valid = in_valid && (in_cmd == CMD_SYNC);
  assign sync_seq   = in_seq;
  assign sync_pkt   = in_pkt;
endmodule

// File: rtl/ipt_checker.sv
module ipt_checker #(
  parameter int NSLOT = 4,
  parameter int SEQ_W = 8,
  parameter int CNT_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [1:0]       in_cmd,
  input logic             in_refuse,
  input logic             issue_kick,
  input logic             pass_done,
  input logic             sync_valid,
  input logic             pop_hit,
  input logic [SEQ_W-1:0] pop_seq,
  input logic             upd_strobe,
  input logic [CNT_W-1:0] tok_count,
  input logic [SEQ_W-1:0] q_seq,
  input logic             q_done
);
  p_refuse_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_refuse |-> (in_valid && !in_cmd[1]));

  p_refuse_no_kick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_refuse |-> !issue_kick);

  p_sync_skips_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sync_valid |-> (!in_refuse && !issue_kick));

  p_kick_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_kick && !pass_done) |=> !issue_kick);

  p_tok_after_upd_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_count != '0) |-> $past(upd_strobe));

  p_tok_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tok_count <= CNT_W'(NSLOT));

  p_query_live_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_hit && (pop_seq == q_seq)) |-> !q_done);
endmodule

bind inst_pkt_table ipt_checker #(
  .NSLOT(NSLOT), .SEQ_W(SEQ_W), .CNT_W(CNT_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_cmd     (in_cmd),
  .in_refuse  (in_refuse),
  .issue_kick (issue_kick),
  .pass_done  (pass_done),
  .sync_valid (sync_valid),
  .pop_hit    (pop_hit),
  .pop_seq    (pop_seq),
  .upd_strobe (upd_strobe),
  .tok_count  (tok_count),
  .q_seq      (q_seq),
  .q_done     (q_done)
);

// File: tb/inst_pkt_table_tb.sv
`timescale 1ns/1ps
module inst_pkt_table_tb;
  localparam int NS  = 4;
  localparam int DP  = 4;
  localparam int SW  = 8;
  localparam int PW  = 16;
  localparam int LIM = 48;
  localparam int CW  = $clog2(NS + 1);

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n;
  logic          in_valid;
  logic [1:0]    in_cmd;
  logic [SW-1:0] in_seq;
  logic [PW-1:0] in_pkt;
  logic          in_refuse, issue_kick, pass_done;
  logic          sync_valid;
  logic [SW-1:0] sync_seq;
  logic [PW-1:0] sync_pkt;
  logic          pop_valid;
  logic [SW-1:0] pop_seq;
  logic          pop_hit;
  logic [PW-1:0] pop_pkt;
  logic          upd_strobe;
  logic [CW-1:0] tok_count;
  logic [SW-1:0] q_seq;
  logic          q_done, stall_flag;

  inst_pkt_table #(.NSLOT(NS), .DEPTH(DP), .SEQ_W(SW), .PKT_W(PW),
                   .STALL_LIMIT(LIM)) u_dut (.*);

  int checks = 0;
  int errors = 0;

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // behavioural reference: live instructions with packet queues
  bit            mv [NS];
  int            mt [NS];
  logic [PW-1:0] mq [NS][$];
  int            ma [NS];
  bit            mbusy;
  int            mtok;

  function automatic int mfind(int s);
    for (int i = 0; i < NS; i++) if (mv[i] && mt[i] == s) return i;
    return -1;
  endfunction

  function automatic int mfree();
    for (int i = 0; i < NS; i++) if (!mv[i]) return i;
    return -1;
  endfunction

  task automatic idle();
    in_valid = 0; in_cmd = 0; in_seq = 0; in_pkt = 0; pass_done = 0;
    pop_valid = 0; pop_seq = 0; upd_strobe = 0; q_seq = 0;
  endtask

  task automatic cyc();
    int  e, pe, nret;
    bit  isrw, acc, phit, st;
    bit  ret [NS];
    #1;
    isrw = in_valid && (in_cmd < 2);
    e    = mfind(int'(in_seq));
    acc  = (e >= 0) ? (mq[e].size() < DP) : (mfree() >= 0);
    pe   = mfind(int'(pop_seq));
    phit = pop_valid && (pe >= 0) && (mq[(pe < 0) ? 0 : pe].size() > 0);
    st   = 0;
    for (int i = 0; i < NS; i++) if (mv[i] && ma[i] >= LIM) st = 1;
    chk("R3", "in_refuse", in_refuse, isrw && !acc);
    chk("R5", "issue_kick", issue_kick, isrw && acc && !mbusy);
    chk("R4", "sync_valid", sync_valid, in_valid && in_cmd == 2);
    if (in_valid && in_cmd == 2) begin
      chk("R4", "sync_seq", sync_seq, in_seq);
      chk("R4", "sync_pkt", sync_pkt, in_pkt);
    end
    chk("R6", "pop_hit", pop_hit, phit);
    if (phit) chk("R2", "pop_pkt", pop_pkt, mq[pe][0]);
    chk("R8", "q_done", q_done, mfind(int'(q_seq)) < 0);
    chk("R7", "tok_count", tok_count, mtok);
    chk("R9", "stall_flag", stall_flag, st);
    @(posedge clk);
    for (int i = 0; i < NS; i++)
      ret[i] = upd_strobe && mv[i] && mq[i].size() == 0 && !(isrw && acc && e == i);
    if (phit) void'(mq[pe].pop_front());
    if (isrw && acc) begin
      if (e < 0) begin
        e = mfree();
        mv[e] = 1; mt[e] = int'(in_seq);
      end
      mq[e].push_back(in_pkt);
    end
    nret = 0;
    for (int i = 0; i < NS; i++) begin
      if (ret[i]) begin mv[i] = 0; nret++; end
      if (!mv[i] || (phit && pe == i) || mq[i].size() == 0) ma[i] = 0;
      else if (ma[i] < LIM) ma[i]++;
    end
    mtok  = upd_strobe ? nret : 0;
    mbusy = (isrw && acc) || (mbusy && !pass_done);
    @(negedge clk);
  endtask

  task automatic put(int cmd, int seq, int pkt);
    idle(); in_valid = 1; in_cmd = 2'(cmd); in_seq = SW'(seq); in_pkt = PW'(pkt);
    q_seq = SW'(seq);
    cyc();
  endtask

  task automatic take(int seq);
    idle(); pop_valid = 1; pop_seq = SW'(seq); q_seq = SW'(seq);
    cyc();
  endtask

  task automatic update();
    idle(); upd_strobe = 1; cyc();
  endtask

  initial begin
    #(200000 * 4);
    checks++; errors++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int unsigned r;
    for (int i = 0; i < NS; i++) begin mv[i] = 0; ma[i] = 0; mq[i].delete(); end
    mbusy = 0; mtok = 0;
    idle();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state
    q_seq = 8'd5; #1;
    chk("R1", "q_done", q_done, 1);
    chk("R1", "tok_count", tok_count, 0);
    chk("R1", "stall_flag", stall_flag, 0);
    chk("R1", "pop_hit", pop_hit, 0);
    @(negedge clk);

    // R2/R5: grouping, ordering, single kick per pass
    put(0, 10, 16'h0a01);
    put(1, 11, 16'h0b01);
    put(1, 10, 16'h0a02);
    put(0, 12, 16'h0c01);
    put(0, 10, 16'h0a03);
    idle(); pass_done = 1; cyc();
    put(1, 11, 16'h0b02);
    // R6: pop of an absent instruction
    take(40);
    take(10); take(10); take(10);
    take(10);
    // R8: emptied but not retired still reported live
    idle(); q_seq = 10; cyc();
    update();                      // R7: one credit next cycle
    idle(); q_seq = 10; cyc();

    // R3: per-instruction capacity and slot exhaustion
    put(0, 11, 16'h0b03); put(0, 11, 16'h0b04); put(0, 11, 16'h0b05);
    put(0, 13, 16'h0d01); put(0, 14, 16'h0e01); put(0, 15, 16'h0f01);
    put(1, 16, 16'h1001);

    // R4: sync bypass and ignored command
    put(2, 20, 16'h5555);
    put(3, 21, 16'h6666);
    idle(); q_seq = 20; cyc();
    idle(); q_seq = 21; cyc();

    // R7: drain all, retire several at once; insert during update keeps slot
    for (int k = 0; k < 4; k++) take(11);
    take(12); take(13); take(14);
    idle(); upd_strobe = 1; in_valid = 1; in_cmd = 0; in_seq = 14; in_pkt = 16'h0e02; cyc();
    idle(); cyc();
    take(14);
    update();
    idle(); cyc();

    // R9: stall timeout then clear by pop
    put(1, 30, 16'h3001);
    idle(); pass_done = 1; cyc();
    for (int k = 0; k < LIM + 4; k++) begin idle(); q_seq = 30; cyc(); end
    take(30);
    update();
    idle(); cyc();

    // mixed stream
    r = 32'h1234_5678;
    for (int k = 0; k < 3000; k++) begin
      r = r * 32'd1664525 + 32'd1013904223;
      idle();
      in_valid   = (r[3:0] < 4'd9);
      in_cmd     = (r[7:4] < 4'd13) ? {1'b0, r[8]} : r[10:9];
      in_seq     = SW'(r[13:11] % 6);
      in_pkt     = PW'(r[31:16]);
      pop_valid  = (r[17:14] < 4'd8);
      pop_seq    = SW'(r[22:20] % 6);
      upd_strobe = (r[26:24] == 3'd0);
      pass_done  = (r[28:27] == 2'd0);
      q_seq      = SW'(r[31:29] % 6);
      cyc();
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule